// File: doc/BRIEF.md
# Posted-CAS Latency Scheduler

This block sits on the controller side of a double-data-rate memory interface. It turns each read or write command strobe into a per-clock schedule that shows when data is on the bus. The command latency has two parts: a posted (additive) latency, for which the memory holds the command internally, and the CAS latency. Read latency is their sum. Write latency is always one clock less than read latency and has no setting of its own. Each burst is 4 or 8 beats long. Two beats move per clock, so a burst occupies 2 or 4 clocks.

The block holds up to four commands in flight, each in its own latency counter. It raises a read window and a write window on the clocks where data is expected. Each window carries the index of the first beat of the pair moving in that clock. The latency and burst settings are taken only while nothing is outstanding. A write is flagged when its data would collide with the data of a read issued earlier.

Top module: `pcas_sched`

## Requirements
- R1: While reset is held, and after it is released with no command issued, rd_win, wr_win, rd_beat, wr_beat, proto_err, cmd_reject and busy are all 0.
- R2: A read accepted in clock k drives rd_win high in clocks k+RL through k+RL+B-1, where RL = cfg_al + cfg_cl and B is the burst length in clocks.
- R3: A write accepted in clock k drives wr_win high in clocks k+WL through k+WL+B-1, with WL = RL - 1.
- R4: cfg_bl8 = 1 selects 8-beat bursts (B = 4 clocks) and cfg_bl8 = 0 selects 4-beat bursts (B = 2 clocks). In the window clock at offset j from the window start, rd_beat or wr_beat equals 2*j, so the values run 0,2 or 0,2,4,6. The beat output is 0 when its window is low.
- R5: A cfg_cl value below 2 is treated as 2 in every latency.
- R6: When no command is outstanding, a command uses the configuration inputs of its own clock, and that configuration is captured. While any command is outstanding, changes on cfg_al, cfg_cl and cfg_bl8 are ignored and new commands use the captured values.
- R7: At most four commands are outstanding. A command that arrives while four are outstanding is not scheduled and produces a one-clock cmd_reject pulse in the next clock.
- R8: proto_err pulses in the clock after an accepted write whose data window would start at or before the last data clock of an earlier read that is still outstanding.
- R9: When two windows of the same kind overlap, the beat output follows the command issued earlier.
- R10: busy is high from the clock after a command is accepted through that command's last data clock. No window is ever high while busy is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_al | input | 3 | Posted (additive) latency in clocks |
| cfg_cl | input | 3 | CAS latency in clocks; values below 2 are treated as 2 |
| cfg_bl8 | input | 1 | 1 = 8-beat burst, 0 = 4-beat burst |
| cmd_valid | input | 1 | Command strobe, one command per clock |
| cmd_write | input | 1 | 1 = write, 0 = read; valid with cmd_valid |
| rd_win | output | 1 | Read data is expected on the bus this clock |
| rd_beat | output | 3 | First beat index of the read pair this clock |
| wr_win | output | 1 | Write data must be driven this clock |
| wr_beat | output | 3 | First beat index of the write pair this clock |
| proto_err | output | 1 | Write data collides with earlier read data (registered) |
| cmd_reject | output | 1 | Previous command dropped because four were outstanding |
| busy | output | 1 | At least one command is outstanding |

## Verification
The hardest case to reach is a fifth command arriving while every counter is still full. Reaching it needs latencies long enough that no counter drains during a burst of back-to-back strobes. The stimulus sets the largest posted and CAS latencies with 8-beat bursts and then strobes five reads on consecutive clocks. The collision boundary is reached directly: a write is placed one, two and three clocks after a read, which gives one early case, one exact-edge case and one safe case. A long stretch of random traffic then changes the configuration while commands are in flight, so that the ignore rule is exercised. A behavioural queue model tracks every outcome clock by clock.

// File: rtl/pcas_pkg.sv
package pcas_pkg;

  typedef int unsigned uint_t;

  typedef enum logic {
    CMD_RD = 1'b0,
    CMD_WR = 1'b1
  } cmd_kind_e;

  localparam uint_t CL_FLOOR = 2;

  function automatic uint_t cas_clamp(input uint_t cl);
    return (cl < CL_FLOOR) ? CL_FLOOR : cl;
  endfunction

  function automatic uint_t read_lat(input uint_t al, input uint_t cl);
    return al + cas_clamp(cl);
  endfunction

  function automatic uint_t write_lat(input uint_t al, input uint_t cl);
    return read_lat(al, cl) - 1;
  endfunction

  function automatic uint_t burst_clks(input logic bl8);
    return bl8 ? 4 : 2;
  endfunction

endpackage

// File: rtl/pcas_slot.sv
module pcas_slot #(
  parameter int AGE_W  = 5,
  parameter int BEAT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              kind_i,
  input  logic [AGE_W-1:0]  lat_i,
  input  logic [AGE_W-1:0]  nclk_i,
  output logic              busy_o,
  output logic              kind_o,
  output logic [AGE_W-1:0]  age_o,
  output logic              in_win_o,
  output logic [BEAT_W-1:0] beat_o
);

  logic              busy_q;
  logic              kind_q;
  logic [AGE_W-1:0]  age_q;
  logic [AGE_W-1:0]  lat_q;
  logic [AGE_W-1:0]  n_q;
  logic [AGE_W-1:0]  end_age;
  logic [AGE_W-1:0]  offset;
  logic              last_clk;

  assign end_age  = lat_q + n_q - AGE_W'(1);
  assign last_clk = busy_q && (age_q == end_age);
  assign offset   = age_q - lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      kind_q <= 1'b0;
      age_q  <= '0;
      lat_q  <= '0;
      n_q    <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      kind_q <= kind_i;
      age_q  <= AGE_W'(1);
      lat_q  <= lat_i;
      n_q    <= nclk_i;
    end else if (last_clk) begin
      busy_q <= 1'b0;
      age_q  <= '0;
    end else if (busy_q) begin
      age_q  <= age_q + AGE_W'(1);
    end
  end

  assign busy_o   = busy_q;
  assign kind_o   = kind_q;
  assign age_o    = age_q;
  assign in_win_o = busy_q && (age_q >= lat_q) && (age_q <= end_age);
  assign beat_o   = in_win_o ? BEAT_W'({offset, 1'b0}) : '0;

endmodule

// File: rtl/pcas_alloc.sv
module pcas_alloc #(
  parameter int N_SLOTS = 4
) (
  input  logic [N_SLOTS-1:0] busy_i,
  input  logic               req_i,
  output logic [N_SLOTS-1:0] grant_o,
  output logic               full_o
);

  logic [N_SLOTS:0] taken;

  assign taken[0] = 1'b0;

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_pick
    assign grant_o[i]  = req_i && !busy_i[i] && !taken[i];
    assign taken[i+1]  = taken[i] || !busy_i[i];
  end

  assign full_o = &busy_i;

endmodule

// File: rtl/pcas_merge.sv
module pcas_merge #(
  parameter int                   N_SLOTS = 4,
  parameter int                   AGE_W   = 5,
  parameter int                   BEAT_W  = 3,
  parameter pcas_pkg::cmd_kind_e  KIND    = pcas_pkg::CMD_RD
) (
  input  logic [N_SLOTS-1:0]             in_win_i,
  input  logic [N_SLOTS-1:0]             kind_i,
  input  logic [N_SLOTS-1:0][AGE_W-1:0]  age_i,
  input  logic [N_SLOTS-1:0][BEAT_W-1:0] beat_i,
  output logic                           win_o,
  output logic [BEAT_W-1:0]              beat_o
);

  logic [AGE_W-1:0] best_age;

  // Oldest command (largest age) in its window owns the beat output.
  always_comb begin
    win_o    = 1'b0;
    best_age = '0;
    beat_o   = '0;
    for (int i = 0; i < N_SLOTS; i++) begin
      if (in_win_i[i] && (kind_i[i] == logic'(KIND)) &&
          (!win_o || (age_i[i] > best_age))) begin
        win_o    = 1'b1;
        best_age = age_i[i];
        beat_o   = beat_i[i];
      end
    end
  end

endmodule

// File: rtl/pcas_hazard.sv
module pcas_hazard #(
  parameter int N_SLOTS = 4,
  parameter int AGE_W   = 5
) (
  input  logic [N_SLOTS-1:0]            busy_i,
  input  logic [N_SLOTS-1:0]            kind_i,
  input  logic [N_SLOTS-1:0][AGE_W-1:0] age_i,
  input  logic [AGE_W-1:0]              nclk_i,
  input  logic                          wr_go_i,
  output logic                          hit_o
);

  logic [N_SLOTS-1:0] clash;

  // A read aged a clocks ends at or after the new write's first data
  // clock exactly when a <= burst clocks (write latency is read latency - 1).
  for (genvar i = 0; i < N_SLOTS; i++) begin : g_cmp
    assign clash[i] = busy_i[i] && (kind_i[i] == logic'(pcas_pkg::CMD_RD)) &&
                      (age_i[i] <= nclk_i);
  end

  assign hit_o = wr_go_i && (|clash);

endmodule

// File: rtl/pcas_sched.sv
module pcas_sched #(
  parameter int N_SLOTS = 4,
  parameter int AL_W    = 3,
  parameter int CL_W    = 3,
  parameter int BEAT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AL_W-1:0]   cfg_al,
  input  logic [CL_W-1:0]   cfg_cl,
  input  logic              cfg_bl8,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  output logic              rd_win,
  output logic [BEAT_W-1:0] rd_beat,
  output logic              wr_win,
  output logic [BEAT_W-1:0] wr_beat,
  output logic              proto_err,
  output logic              cmd_reject,
  output logic              busy
);

  import pcas_pkg::*;

  localparam int MAX_LAT = (2**AL_W - 1) + (2**CL_W - 1);
  localparam int MAX_AGE = MAX_LAT + 4;
  localparam int AGE_W   = $clog2(MAX_AGE + 1);

  // captured configuration
  logic [AL_W-1:0] al_q;
  logic [CL_W-1:0] cl_q;
  logic            bl8_q;

  // configuration in force this clock
  logic [AL_W-1:0]  live_al;
  logic [CL_W-1:0]  live_cl;
  logic             live_bl8;
  logic [AGE_W-1:0] live_rl;
  logic [AGE_W-1:0] live_wl;
  logic [AGE_W-1:0] live_n;
  logic [AGE_W-1:0] load_lat;

  // named internal events
  logic                           pipe_busy;
  logic                           slots_full;
  logic                           cmd_accept;
  logic                           cmd_drop;
  logic                           hazard_hit;
  logic [N_SLOTS-1:0]             slot_load;
  logic [N_SLOTS-1:0]             slot_busy;
  logic [N_SLOTS-1:0]             slot_kind;
  logic [N_SLOTS-1:0]             slot_win;
  logic [N_SLOTS-1:0][AGE_W-1:0]  slot_age;
  logic [N_SLOTS-1:0][BEAT_W-1:0] slot_beat;

  logic err_q;
  logic rej_q;

  assign pipe_busy = |slot_busy;

  assign live_al  = pipe_busy ? al_q  : cfg_al;
  assign live_cl  = pipe_busy ? cl_q  : cfg_cl;
  assign live_bl8 = pipe_busy ? bl8_q : cfg_bl8;

  assign live_rl  = AGE_W'(read_lat(uint_t'(live_al), uint_t'(live_cl)));
  assign live_wl  = AGE_W'(write_lat(uint_t'(live_al), uint_t'(live_cl)));
  assign live_n   = AGE_W'(burst_clks(live_bl8));
  assign load_lat = cmd_write ? live_wl : live_rl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_q  <= '0;
      cl_q  <= '0;
      bl8_q <= 1'b0;
    end else if (!pipe_busy) begin
      al_q  <= cfg_al;
      cl_q  <= cfg_cl;
      bl8_q <= cfg_bl8;
    end
  end

  pcas_alloc #(.N_SLOTS(N_SLOTS)) u_alloc (
    .busy_i  (slot_busy),
    .req_i   (cmd_valid),
    .grant_o (slot_load),
    .full_o  (slots_full)
  );

  assign cmd_accept = cmd_valid && !slots_full;
  assign cmd_drop   = cmd_valid && slots_full;

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    pcas_slot #(.AGE_W(AGE_W), .BEAT_W(BEAT_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (slot_load[i]),
      .kind_i   (cmd_write),
      .lat_i    (load_lat),
      .nclk_i   (live_n),
      .busy_o   (slot_busy[i]),
      .kind_o   (slot_kind[i]),
      .age_o    (slot_age[i]),
      .in_win_o (slot_win[i]),
      .beat_o   (slot_beat[i])
    );
  end

  pcas_hazard #(.N_SLOTS(N_SLOTS), .AGE_W(AGE_W)) u_hazard (
    .busy_i  (slot_busy),
    .kind_i  (slot_kind),
    .age_i   (slot_age),
    .nclk_i  (live_n),
    .wr_go_i (cmd_accept && cmd_write),
    .hit_o   (hazard_hit)
  );

  pcas_merge #(.N_SLOTS(N_SLOTS), .AGE_W(AGE_W), .BEAT_W(BEAT_W), .KIND(CMD_RD)) u_rd_merge (
    .in_win_i (slot_win),
    .kind_i   (slot_kind),
    .age_i    (slot_age),
    .beat_i   (slot_beat),
    .win_o    (rd_win),
    .beat_o   (rd_beat)
  );

  pcas_merge #(.N_SLOTS(N_SLOTS), .AGE_W(AGE_W), .BEAT_W(BEAT_W), .KIND(CMD_WR)) u_wr_merge (
    .in_win_i (slot_win),
    .kind_i   (slot_kind),
    .age_i    (slot_age),
    .beat_i   (slot_beat),
    .win_o    (wr_win),
    .beat_o   (wr_beat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      rej_q <= 1'b0;
    end else begin
      err_q <= hazard_hit;
      rej_q <= cmd_drop;
    end
  end

  assign proto_err  = err_q;
  assign cmd_reject = rej_q;
  assign busy       = pipe_busy;

endmodule

// File: rtl/pcas_sched_chk.sv
module pcas_sched_chk #(
  parameter int N_SLOTS = 4,
  parameter int BEAT_W  = 3,
  parameter int CFG_W   = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               cmd_write,
  input logic               rd_win,
  input logic [BEAT_W-1:0]  rd_beat,
  input logic               wr_win,
  input logic [BEAT_W-1:0]  wr_beat,
  input logic               proto_err,
  input logic               cmd_reject,
  input logic               busy,
  input logic [N_SLOTS-1:0] slot_busy,
  input logic [N_SLOTS-1:0] slot_load,
  input logic [CFG_W-1:0]   hold_cfg
);

  p_rd_first_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_win) |-> (rd_beat == '0));

  p_wr_first_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_win) |-> (wr_beat == '0));

  p_hold_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(hold_cfg));

  p_single_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_load));

  p_reject_when_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |-> ($past(cmd_valid) && $past(&slot_busy)));

  p_err_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(cmd_valid && cmd_write));

  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !(&slot_busy)) |=> busy);

  p_quiet_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_win && !wr_win));

endmodule

bind pcas_sched pcas_sched_chk #(
  .N_SLOTS (N_SLOTS),
  .BEAT_W  (BEAT_W),
  .CFG_W   (AL_W + CL_W + 1)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_write  (cmd_write),
  .rd_win     (rd_win),
  .rd_beat    (rd_beat),
  .wr_win     (wr_win),
  .wr_beat    (wr_beat),
  .proto_err  (proto_err),
  .cmd_reject (cmd_reject),
  .busy       (busy),
  .slot_busy  (slot_busy),
  .slot_load  (slot_load),
  .hold_cfg   ({al_q, cl_q, bl8_q})
);

// File: tb/tb_pcas_sched.sv
module tb_pcas_sched;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] cfg_al, cfg_cl;
  logic       cfg_bl8, cmd_valid, cmd_write;
  logic       rd_win, wr_win, proto_err, cmd_reject, busy;
  logic [2:0] rd_beat, wr_beat;

  always #10 clk = ~clk;

  pcas_sched dut (
    .clk(clk), .rst_n(rst_n), .cfg_al(cfg_al), .cfg_cl(cfg_cl), .cfg_bl8(cfg_bl8),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .rd_win(rd_win), .rd_beat(rd_beat), .wr_win(wr_win), .wr_beat(wr_beat),
    .proto_err(proto_err), .cmd_reject(cmd_reject), .busy(busy)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  int    cyc     = 0;
  bit    checking = 0;
  bit    finished = 0;
  string phase = "R1 reset";

  typedef struct { int t; bit wr; int lat; int n; } ent_t;
  ent_t q[$];

  int h_al, h_cl, m_rl, m_n, m_nb;
  bit h_bl8, exp_err, exp_rej;

  function automatic bit alive(ent_t e, int c);
    return (c > e.t) && (c <= e.t + e.lat + e.n - 1);
  endfunction

  function automatic int outstanding(int c);
    int k = 0;
    foreach (q[i]) if (alive(q[i], c)) k++;
    return k;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s [%s] cycle %0d: actual %0d expected %0d", tag, phase, cyc, act, exp);
    end
  endtask

  // reference model: advances once per rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      cyc = 0; exp_err = 0; exp_rej = 0;
      h_al = 0; h_cl = 0; h_bl8 = 0;
    end else begin
      m_nb = outstanding(cyc);
      if (m_nb == 0) begin
        h_al = cfg_al; h_cl = cfg_cl; h_bl8 = cfg_bl8;
      end
      exp_err = 0;
      exp_rej = 0;
      if (cmd_valid) begin
        if (m_nb >= 4) exp_rej = 1;
        else begin
          m_rl = h_al + ((h_cl < 2) ? 2 : h_cl);
          m_n  = h_bl8 ? 4 : 2;
          if (cmd_write)
            foreach (q[i])
              if (!q[i].wr && alive(q[i], cyc) && (cyc - q[i].t) <= m_n) exp_err = 1;
          q.push_back('{cyc, cmd_write, cmd_write ? m_rl - 1 : m_rl, m_n});
        end
      end
      cyc++;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && checking) begin
      bit erw, eww, eb;
      int erb, ewb, trd, twr, w;
      erw = 0; eww = 0; erb = 0; ewb = 0; trd = 0; twr = 0; eb = 0;
      foreach (q[i]) begin
        w = cyc - q[i].t - q[i].lat;
        if (alive(q[i], cyc)) eb = 1;
        if (w >= 0 && w < q[i].n) begin
          if (!q[i].wr && (!erw || q[i].t < trd)) begin erw = 1; trd = q[i].t; erb = 2 * w; end
          if ( q[i].wr && (!eww || q[i].t < twr)) begin eww = 1; twr = q[i].t; ewb = 2 * w; end
        end
      end
      chk("R2 rd_win", int'(rd_win), int'(erw));
      chk("R3 wr_win", int'(wr_win), int'(eww));
      chk("R4 R9 rd_beat", int'(rd_beat), erb);
      chk("R4 R9 wr_beat", int'(wr_beat), ewb);
      chk("R8 proto_err", int'(proto_err), int'(exp_err));
      chk("R7 cmd_reject", int'(cmd_reject), int'(exp_rej));
      chk("R10 busy", int'(busy), int'(eb));
    end
  end

  task automatic setcfg(input int al, input int cl, input bit b8);
    cfg_al = 3'(al); cfg_cl = 3'(cl); cfg_bl8 = b8;
  endtask

  task automatic issue(input bit wr);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_write = 1'b0;
  endtask

  // issue a command and keep the strobe low for gap clocks after it
  task automatic issue_gap(input bit wr, input int gap);
    cmd_valid = 1'b1; cmd_write = wr;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_write = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_write = 1'b0;
    setcfg(0, 0, 0);
    repeat (3) @(negedge clk);
    // R1: outputs quiet while reset is held
    chk("R1 reset rd_win", int'(rd_win), 0);
    chk("R1 reset wr_win", int'(wr_win), 0);
    chk("R1 reset beats", int'(rd_beat) + int'(wr_beat), 0);
    chk("R1 reset flags", int'(proto_err) + int'(cmd_reject) + int'(busy), 0);
    rst_n = 1'b1;
    checking = 1;
    idle(3);

    phase = "R2 R4 al2 cl3 bl8";
    setcfg(2, 3, 1); issue(0); idle(14);

    phase = "R3 al0 cl3 bl4";
    setcfg(0, 3, 0); issue(1); idle(10);

    phase = "R3 R2 al1 cl3 bl4";
    setcfg(1, 3, 0); issue(1); idle(10); issue(0); idle(10);

    phase = "R8 write one clock after read";
    setcfg(1, 3, 0); @(negedge clk);
    issue_gap(0, 0); issue_gap(1, 14);

    phase = "R8 write at the overlap edge";
    issue_gap(0, 1); issue_gap(1, 14);

    phase = "R8 write just clear of the read";
    issue_gap(0, 2); issue_gap(1, 14);

    phase = "R5 cl below floor";
    setcfg(0, 1, 0); issue_gap(0, 0); issue_gap(1, 10);
    setcfg(1, 0, 1); issue_gap(1, 12);

    phase = "R6 cfg change while busy";
    setcfg(3, 4, 1); issue_gap(0, 1);
    setcfg(0, 2, 0); idle(1); issue_gap(0, 20);
    issue_gap(0, 10);

    phase = "R7 fifth command while full";
    setcfg(7, 7, 1);
    repeat (5) issue_gap(0, 0);
    idle(15); issue_gap(1, 30);

    phase = "R9 overlapping reads";
    setcfg(0, 4, 1); issue_gap(0, 0); issue_gap(0, 12);
    phase = "R9 overlapping writes";
    issue_gap(1, 0); issue_gap(1, 12);

    phase = "R10 random traffic";
    for (int i = 0; i < 1500; i++) begin
      if (i % 37 == 0)
        setcfg(int'($urandom_range(0, 7)), int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));
      cmd_valid = ($urandom_range(0, 2) == 0);
      cmd_write = 1'($urandom_range(0, 1));
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    idle(25);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog [%s]: actual hung expected done", phase);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule